// File: doc/BRIEF.md
# PLL Configuration Sequencer

This block brings a memory-clock PLL from its power-up state into a programmed state by writing two 32-bit control registers over a simple register write bus. After a start pulse it waits until the main PLL and its controller report ready. It then issues a fixed series of writes. The writes turn on loop saturation, place the PLL in bypass, hold the PLL in reset, and finally load the multiplier, the reference divider and a bandwidth-adjust value. The bandwidth-adjust value is derived from the multiplier, and its twelve bits are split across the two registers.

Every write is a read-modify-write of a register image kept inside the block. The block is the only writer of these registers, and all of their fields reset to zero. Each write therefore keeps what earlier writes put there and changes only the fields of its own step. A write is held on the bus until the target acknowledges it. When the last write is accepted, a done flag rises and stays high until the next start.

Top module: `pll_cfg_seq`

## Requirements
- R1: After reset `wr_en_o` and `done_o` are 0 and both register images are zero, so the first write after reset carries the value 0x0000_0040.
- R2: An accepted start moves the block into a wait phase. No write is issued while `main_rdy_i` is low, and the first write is issued in the cycle after `main_rdy_i` is sampled high.
- R3: The writes go out in this order: register 1, register 0, register 1, register 0, register 1. `wr_sel_o` = 1 selects register 1 and `wr_sel_o` = 0 selects register 0.
- R4: A write keeps `wr_en_o`, `wr_sel_o` and `wr_data_o` unchanged until `wr_ack_i` is sampled high. Each acknowledged cycle completes exactly one write.
- R5: The first write is the register-1 image with bit 6 (saturation enable) set.
- R6: The second write is the register-0 image with bit 23 (bypass) set.
- R7: The third write is the register-1 image with bit 13 (PLL reset) set.
- R8: The fourth write is register 0. It carries the multiplier in bits 18:6, the divider in bits 5:0 and bandwidth-adjust bits 7:0 in bits 31:24. Bit 23 is kept, and bits 22:19 are zero.
- R9: The fifth write is register 1, with bandwidth-adjust bits 11:8 in bits 3:0. The bandwidth-adjust value is the multiplier shifted right by one (15 gives 7).
- R10: The multiplier and divider are sampled when a start is accepted. Later changes on `mult_i` and `div_i` do not affect that sequence.
- R11: `done_o` rises in the cycle after the fifth write is acknowledged. It stays high until a start is accepted, which clears it.
- R12: A start pulse during the wait phase or during any write has no effect on the sequence.
- R13: A second sequence without a reset between begins from the images left by the previous one, so fields set earlier stay set in later writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Start request, taken in idle or done |
| main_rdy_i | input | 1 | Main PLL and controller are initialised |
| mult_i | input | 13 | Multiplier setting |
| div_i | input | 6 | Reference divider setting |
| wr_en_o | output | 1 | Write request, held until acknowledged |
| wr_sel_o | output | 1 | Target register: 0 or 1 |
| wr_data_o | output | 32 | Full register word to write |
| wr_ack_i | input | 1 | Target accepts the current write |
| done_o | output | 1 | Sequence complete |

## Verification
The behaviour that is hardest to reach from the ports is read-modify-write carrying over between runs. A run only shows it when the images are not empty, which means after an earlier run and with no reset in between. The stimulus table therefore chains several sequences back to back. Each row has different multiplier, divider, ready-delay and acknowledge-delay values, and rows that shrink the multiplier show that stale bandwidth-adjust bits are replaced. Separate directed runs apply a reset in the middle of a write and send start pulses into the wait phase and into stalled writes.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;

  localparam int DATA_W    = 32;
  localparam int MULT_W    = 13;
  localparam int DIV_W     = 6;
  localparam int BWA_W     = 12;
  localparam int BWA_LO_W  = 8;
  localparam int BWA_HI_W  = BWA_W - BWA_LO_W;
  localparam int NUM_REGS  = 2;

  // register 0 field placement
  localparam int R0_DIV_LSB  = 0;
  localparam int R0_MULT_LSB = 6;
  localparam int R0_BYP_BIT  = 23;
  localparam int R0_BWA_LSB  = 24;
  // register 1 field placement
  localparam int R1_BWA_LSB  = 0;
  localparam int R1_SAT_BIT  = 6;
  localparam int R1_RST_BIT  = 13;

  localparam logic REG_SEL_0 = 1'b0;
  localparam logic REG_SEL_1 = 1'b1;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WAIT = 3'd1,
    ST_SAT  = 3'd2,
    ST_BYP  = 3'd3,
    ST_RST  = 3'd4,
    ST_PRG0 = 3'd5,
    ST_PRG1 = 3'd6,
    ST_DONE = 3'd7
  } seq_state_t;

  function automatic logic [BWA_W-1:0] bwa_of(input logic [MULT_W-1:0] mult);
    logic [MULT_W-1:0] half;
    half = mult >> 1;
    return half[BWA_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] field_mask(input int lsb, input int width);
    logic [DATA_W-1:0] ones;
    ones = (DATA_W'(1) << width) - DATA_W'(1);
    return ones << lsb;
  endfunction

  function automatic logic [DATA_W-1:0] put_field(input logic [DATA_W-1:0] word,
                                                  input logic [DATA_W-1:0] val,
                                                  input int lsb, input int width);
    logic [DATA_W-1:0] m;
    m = field_mask(lsb, width);
    return (word & ~m) | ((val << lsb) & m);
  endfunction

endpackage

// File: rtl/pll_cfg_ctrl.sv
module pll_cfg_ctrl
  import pll_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       main_rdy_i,
  input  logic       wr_ack_i,
  output seq_state_t state_o,
  output logic       wr_en_o,
  output logic       done_o,
  output logic       capture_o
);

  seq_state_t state_q, state_d;
  logic       at_rest;

  assign at_rest = (state_q == ST_IDLE) || (state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE: if (start_i)    state_d = ST_WAIT;
      ST_WAIT:          if (main_rdy_i) state_d = ST_SAT;
      ST_SAT:           if (wr_ack_i)   state_d = ST_BYP;
      ST_BYP:           if (wr_ack_i)   state_d = ST_RST;
      ST_RST:           if (wr_ack_i)   state_d = ST_PRG0;
      ST_PRG0:          if (wr_ack_i)   state_d = ST_PRG1;
      ST_PRG1:          if (wr_ack_i)   state_d = ST_DONE;
      default:                          state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    wr_en_o = 1'b0;
    unique case (state_q)
      ST_SAT, ST_BYP, ST_RST, ST_PRG0, ST_PRG1: wr_en_o = 1'b1;
      default:                                  wr_en_o = 1'b0;
    endcase
  end

  assign done_o    = (state_q == ST_DONE);
  assign capture_o = at_rest && start_i;
  assign state_o   = state_q;

endmodule

// File: rtl/pll_cfg_settings.sv
module pll_cfg_settings
  import pll_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture_i,
  input  logic [MULT_W-1:0] mult_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic [MULT_W-1:0] mult_o,
  output logic [DIV_W-1:0]  div_o,
  output logic [BWA_W-1:0]  bwa_o
);

  logic [MULT_W-1:0] mult_q;
  logic [DIV_W-1:0]  div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mult_q <= '0;
      div_q  <= '0;
    end else if (capture_i) begin
      mult_q <= mult_i;
      div_q  <= div_i;
    end
  end

  assign mult_o = mult_q;
  assign div_o  = div_q;
  assign bwa_o  = bwa_of(mult_q);

endmodule

// File: rtl/pll_cfg_image.sv
module pll_cfg_image
  import pll_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_t        state_i,
  input  logic              wr_en_i,
  input  logic              wr_ack_i,
  input  logic [MULT_W-1:0] mult_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [BWA_W-1:0]  bwa_i,
  output logic              wr_sel_o,
  output logic [DATA_W-1:0] wr_data_o
);

  logic [DATA_W-1:0] img_q [NUM_REGS];
  logic              commit;
  logic [DATA_W-1:0] prg0_word;
  logic [DATA_W-1:0] bwa_lo_w, bwa_hi_w, mult_w, div_w;

  assign commit   = wr_en_i && wr_ack_i;
  assign bwa_lo_w = DATA_W'(bwa_i[BWA_LO_W-1:0]);
  assign bwa_hi_w = DATA_W'(bwa_i[BWA_W-1:BWA_LO_W]);
  assign mult_w   = DATA_W'(mult_i);
  assign div_w    = DATA_W'(div_i);

  always_comb begin
    prg0_word = img_q[0];
    prg0_word = put_field(prg0_word, mult_w,   R0_MULT_LSB, MULT_W);
    prg0_word = put_field(prg0_word, div_w,    R0_DIV_LSB,  DIV_W);
    prg0_word = put_field(prg0_word, bwa_lo_w, R0_BWA_LSB,  BWA_LO_W);
  end

  always_comb begin
    wr_sel_o  = REG_SEL_0;
    wr_data_o = '0;
    unique case (state_i)
      ST_SAT: begin
        wr_sel_o  = REG_SEL_1;
        wr_data_o = img_q[1] | (DATA_W'(1) << R1_SAT_BIT);
      end
      ST_BYP: begin
        wr_sel_o  = REG_SEL_0;
        wr_data_o = img_q[0] | (DATA_W'(1) << R0_BYP_BIT);
      end
      ST_RST: begin
        wr_sel_o  = REG_SEL_1;
        wr_data_o = img_q[1] | (DATA_W'(1) << R1_RST_BIT);
      end
      ST_PRG0: begin
        wr_sel_o  = REG_SEL_0;
        wr_data_o = prg0_word;
      end
      ST_PRG1: begin
        wr_sel_o  = REG_SEL_1;
        wr_data_o = put_field(img_q[1], bwa_hi_w, R1_BWA_LSB, BWA_HI_W);
      end
      default: begin
        wr_sel_o  = REG_SEL_0;
        wr_data_o = '0;
      end
    endcase
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_img
    logic hit;
    assign hit = commit && (wr_sel_o == 1'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   img_q[g] <= '0;
      else if (hit) img_q[g] <= wr_data_o;
    end
  end

endmodule

// File: rtl/pll_cfg_seq.sv
module pll_cfg_seq
  import pll_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              main_rdy_i,
  input  logic [MULT_W-1:0] mult_i,
  input  logic [DIV_W-1:0]  div_i,
  output logic              wr_en_o,
  output logic              wr_sel_o,
  output logic [DATA_W-1:0] wr_data_o,
  input  logic              wr_ack_i,
  output logic              done_o
);

  seq_state_t        state;
  logic              capture;
  logic [MULT_W-1:0] mult_q;
  logic [DIV_W-1:0]  div_q;
  logic [BWA_W-1:0]  bwa;

  pll_cfg_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .main_rdy_i (main_rdy_i),
    .wr_ack_i   (wr_ack_i),
    .state_o    (state),
    .wr_en_o    (wr_en_o),
    .done_o     (done_o),
    .capture_o  (capture)
  );

  pll_cfg_settings u_set (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture_i (capture),
    .mult_i    (mult_i),
    .div_i     (div_i),
    .mult_o    (mult_q),
    .div_o     (div_q),
    .bwa_o     (bwa)
  );

  pll_cfg_image u_img (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_i   (state),
    .wr_en_i   (wr_en_o),
    .wr_ack_i  (wr_ack_i),
    .mult_i    (mult_q),
    .div_i     (div_q),
    .bwa_i     (bwa),
    .wr_sel_o  (wr_sel_o),
    .wr_data_o (wr_data_o)
  );

endmodule

// File: rtl/pll_cfg_seq_chk.sv
module pll_cfg_seq_chk
  import pll_cfg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              wr_en_o,
  input logic              wr_sel_o,
  input logic [DATA_W-1:0] wr_data_o,
  input logic              wr_ack_i,
  input logic              done_o
);

  // R4
  write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o && !wr_ack_i |=> wr_en_o && $stable(wr_sel_o) && $stable(wr_data_o));

  // R11
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start_i |=> done_o);

  // R11
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(wr_en_o && wr_ack_i && (wr_sel_o == REG_SEL_1)));

  // R3
  quiet_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && wr_en_o));

  // R5
  sat_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o && (wr_sel_o == REG_SEL_1) |-> wr_data_o[R1_SAT_BIT]);

  // R6
  byp_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o && (wr_sel_o == REG_SEL_0) |-> wr_data_o[R0_BYP_BIT]);

  // R8
  r0_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o && (wr_sel_o == REG_SEL_0) |-> (wr_data_o[22:19] == 4'd0));

  // R9
  bwa_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o && (wr_sel_o == REG_SEL_0) |->
      (wr_data_o[31:24] == wr_data_o[R0_MULT_LSB+8:R0_MULT_LSB+1]));

endmodule

bind pll_cfg_seq pll_cfg_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .wr_en_o   (wr_en_o),
  .wr_sel_o  (wr_sel_o),
  .wr_data_o (wr_data_o),
  .wr_ack_i  (wr_ack_i),
  .done_o    (done_o)
);

// File: tb/pll_cfg_seq_tb.sv
module pll_cfg_seq_tb;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 20000;
  localparam int  NVEC       = 6;

  // {ack_dly[31:28], rdy_dly[27:24], pad[23:19], mult[18:6], div[5:0]}
  localparam logic [31:0] VEC [NVEC] = '{
    {4'd0, 4'd0, 5'd0, 13'd15,      6'd1},
    {4'd2, 4'd3, 5'd0, 13'h1FFF,    6'h3F},
    {4'd1, 4'd0, 5'd0, 13'd0,       6'd0},
    {4'd3, 4'd1, 5'd0, 13'h1000,    6'h20},
    {4'd0, 4'd2, 5'd0, 13'h0AAA,    6'h15},
    {4'd1, 4'd0, 5'd0, 13'h1555,    6'h2A}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, main_rdy_i, wr_ack_i;
  logic [12:0] mult_i;
  logic [5:0]  div_i;
  logic        wr_en_o, wr_sel_o, done_o;
  logic [31:0] wr_data_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] m_r0, m_r1;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_cfg_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .main_rdy_i(main_rdy_i),
    .mult_i(mult_i), .div_i(div_i), .wr_en_o(wr_en_o), .wr_sel_o(wr_sel_o),
    .wr_data_o(wr_data_o), .wr_ack_i(wr_ack_i), .done_o(done_o)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic exp_sel, input logic [31:0] exp_data,
                          input int ack_dly, input logic poke, input string req);
    int waited = 0;
    while (!wr_en_o && waited < 20) begin
      @(negedge clk);
      waited++;
    end
    chk(wr_en_o == 1'b1, "R3 write request", 32'(wr_en_o), 32'd1);
    chk(wr_sel_o == exp_sel, {req, " register select"}, 32'(wr_sel_o), 32'(exp_sel));
    chk(wr_data_o == exp_data, {req, " write data"}, wr_data_o, exp_data);
    for (int k = 0; k < ack_dly; k++) begin
      start_i = poke;
      @(negedge clk);
      start_i = 1'b0;
      chk(wr_en_o && (wr_sel_o == exp_sel) && (wr_data_o == exp_data),
          "R4 R12 held write", wr_data_o, exp_data);
    end
    start_i  = poke;
    wr_ack_i = 1'b1;
    @(negedge clk);
    wr_ack_i = 1'b0;
    start_i  = 1'b0;
  endtask

  task automatic run_seq(input logic [12:0] mult, input logic [5:0] div,
                         input int rdy_dly, input int ack_dly, input logic poke);
    logic [11:0] bw;
    bw = 12'(mult >> 1);
    mult_i     = mult;
    div_i      = div;
    main_rdy_i = (rdy_dly == 0);
    start_i    = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // R10: disturb the settings after capture
    mult_i = ~mult;
    div_i  = ~div;
    chk(done_o == 1'b0, "R11 done cleared by start", 32'(done_o), 32'd0);
    for (int k = 0; k < rdy_dly; k++) begin
      chk(wr_en_o == 1'b0, "R2 no write before ready", 32'(wr_en_o), 32'd0);
      start_i = poke;
      @(negedge clk);
      start_i = 1'b0;
    end
    main_rdy_i = 1'b1;
    if (rdy_dly != 0) @(negedge clk);
    m_r1 = m_r1 | (32'd1 << 6);
    do_write(1'b1, m_r1, ack_dly, poke, "R5 step1");
    m_r0 = m_r0 | (32'd1 << 23);
    do_write(1'b0, m_r0, ack_dly, poke, "R6 step2");
    m_r1 = m_r1 | (32'd1 << 13);
    do_write(1'b1, m_r1, ack_dly, poke, "R7 step3");
    m_r0 = {bw[7:0], m_r0[23:19], mult, div};
    do_write(1'b0, m_r0, ack_dly, poke, "R8 R10 R13 step4");
    m_r1 = {m_r1[31:4], bw[11:8]};
    do_write(1'b1, m_r1, ack_dly, poke, "R9 R13 step5");
    chk(done_o == 1'b1, "R11 done after last ack", 32'(done_o), 32'd1);
    repeat (3) @(negedge clk);
    chk(done_o && !wr_en_o, "R11 done held", 32'(done_o), 32'd1);
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; main_rdy_i = 1'b0; wr_ack_i = 1'b0;
    mult_i = '0; div_i = '0;
    m_r0 = '0; m_r1 = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!wr_en_o && !done_o, "R1 reset outputs", {30'd0, wr_en_o, done_o}, 32'd0);

    // R13: table walked back to back, no reset between rows
    for (int i = 0; i < NVEC; i++) begin
      logic [31:0] v;
      v = VEC[i];
      run_seq(v[18:6], v[5:0], int'(v[27:24]), int'(v[31:28]), 1'b0);
    end

    // R12: start pokes in the wait phase and stalled writes
    run_seq(13'd100, 6'd9, 3, 2, 1'b1);

    // R1: reset in the middle of a stalled write
    main_rdy_i = 1'b1;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    chk(wr_en_o == 1'b1, "R2 write after ready", 32'(wr_en_o), 32'd1);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!wr_en_o && !done_o, "R1 reset mid write", {30'd0, wr_en_o, done_o}, 32'd0);
    rst_n = 1'b1;
    m_r0 = '0; m_r1 = '0;
    @(negedge clk);
    chk(!wr_en_o && !done_o, "R1 idle after reset", {30'd0, wr_en_o, done_o}, 32'd0);
    run_seq(13'd15, 6'd2, 0, 0, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule